// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block sits next to a word-addressed shared memory that several hardware threads use in turn, one request per clock, as the time slots of a barrel-style core do. It turns a plain memory port into one that supports atomic read-modify-write sequences built from two simple accesses.

A load-linked request reads a word and records, for the issuing thread only, a reservation on the aligned block that holds the word. A later store-conditional from that thread writes only if the reservation is still valid for that block. The response carries 1 for success and 0 for failure, so software loops until it sees a non-zero result. Reservations are lost when any thread writes into the reserved block, when the owner takes an interrupt or exception, when the owner issues another load-linked, and after every store-conditional.

Each thread has one reservation register: a valid bit and a block tag. The block size is a parameter (`BLK_LOG2` words per block, 16 words of 32 bits by default). Requests are sampled on a rising edge. The response is registered and appears after that same edge.

Top module: `resv_monitor`

## Requirements
- R1: After reset no thread holds a reservation, so a store-conditional gets response 0 and leaves memory unchanged. Memory reads as zero and `rsp_valid` is low.
- R2: Every request (`req_op` 0 = load, 1 = store, 2 = load-linked, 3 = store-conditional) gets exactly one response with `rsp_valid` high, one clock after it is sampled, carrying the requester's id. A load or load-linked returns the word held before that edge.
- R3: A store-conditional succeeds when the issuer holds a valid reservation whose block equals `req_addr[AW-1:BLK_LOG2]`. It writes `req_wdata` and responds 1. Any word in the block may be the target.
- R4: A store-conditional without a matching valid reservation writes nothing and responds 0. A store responds 0.
- R5: Every store-conditional, whether it succeeds or fails, clears the issuer's reservation.
- R6: A store, or a successful store-conditional, by another thread into the reserved block clears the reservation. A write to a different block leaves it intact.
- R7: An interrupt or exception reported for a thread (`trap_valid`, `trap_tid`) clears that thread's reservation, and only that one.
- R8: A new load-linked replaces the thread's earlier reservation, so a store-conditional to the old block fails.
- R9: When a store-conditional succeeds, all other threads' reservations on that block clear in the same cycle. A failed store-conditional clears no other thread's reservation.
- R10: A plain store by the owner into its own reserved block clears its reservation. A plain load does not.
- R11: A trap for a thread in the same cycle as that thread's store-conditional makes the store-conditional fail.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 2 | 0 load, 1 store, 2 load-linked, 3 store-conditional |
| req_tid | input | $clog2(NTHREADS) | Issuing thread |
| req_addr | input | AW | Word address |
| req_wdata | input | DW | Store data |
| trap_valid | input | 1 | Interrupt or exception taken this cycle |
| trap_tid | input | $clog2(NTHREADS) | Thread taking the trap |
| rsp_valid | output | 1 | Response present |
| rsp_tid | output | $clog2(NTHREADS) | Thread the response belongs to |
| rsp_data | output | DW | Read data, or 1/0 success flag for store-conditional |

## Verification
Each response is due exactly one clock after the rising edge that samples its request, and the reservation update takes effect at that same edge. The driver applies a request on a falling edge and pushes the expected response into a queue. The monitor checks responses on the next falling edge, so every check falls in the cycle where the result becomes valid. A response with nothing queued counts as a failure, and so do items still queued at the end. Effects that cannot be seen directly, such as a write that was blocked or a reservation that was lost, are checked through later loads and store-conditionals.

// File: rtl/resv_pkg.sv
package resv_pkg;

    typedef enum logic [1:0] {
        OP_LOAD  = 2'd0,
        OP_STORE = 2'd1,
        OP_LL    = 2'd2,
        OP_SC    = 2'd3
    } mem_op_e;

endpackage

// File: rtl/resv_slot.sv
module resv_slot
    import resv_pkg::*;
#(
    parameter int TID  = 0,
    parameter int TIDW = 2,
    parameter int TAGW = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  mem_op_e         req_op,
    input  logic [TIDW-1:0] req_tid,
    input  logic [TAGW-1:0] req_tag,
    input  logic            mem_write,
    input  logic            trap_valid,
    input  logic [TIDW-1:0] trap_tid,
    output logic            slot_vld,
    output logic [TAGW-1:0] slot_tag
);

    typedef struct packed {
        logic            vld;
        logic [TAGW-1:0] tag;
    } slot_t;

    localparam logic [TIDW-1:0] MY_ID = TIDW'(TID);

    slot_t st_d, st_q;
    logic  own_req;
    logic  blk_hit;

    always_comb begin
        st_d    = st_q;
        own_req = (req_tid == MY_ID);
        blk_hit = (st_q.tag == req_tag);
        if (trap_valid && trap_tid == MY_ID) begin
            // a trap on this thread wins over anything it issues this cycle
            st_d.vld = 1'b0;
        end else if (req_valid) begin
            if (own_req) begin
                unique case (req_op)
                    OP_LL: begin
                        st_d.vld = 1'b1;
                        st_d.tag = req_tag;
                    end
                    OP_SC:    st_d.vld = 1'b0;
                    OP_STORE: if (blk_hit) st_d.vld = 1'b0;
                    default:  ;
                endcase
            end else if (mem_write && blk_hit) begin
                st_d.vld = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign slot_vld = st_q.vld;
    assign slot_tag = st_q.tag;

endmodule

// File: rtl/resv_mem.sv
module resv_mem #(
    parameter int AW = 8,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] arr_q [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                arr_q[i] <= '0;
            end
        end else if (wr_en) begin
            arr_q[addr] <= wdata;
        end
    end

    assign rdata = arr_q[addr];

endmodule

// File: rtl/resv_monitor.sv
module resv_monitor
    import resv_pkg::*;
#(
    parameter int NTHREADS = 4,
    parameter int AW       = 8,
    parameter int DW       = 32,
    parameter int BLK_LOG2 = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        req_valid,
    input  logic [1:0]                  req_op,
    input  logic [$clog2(NTHREADS)-1:0] req_tid,
    input  logic [AW-1:0]               req_addr,
    input  logic [DW-1:0]               req_wdata,
    input  logic                        trap_valid,
    input  logic [$clog2(NTHREADS)-1:0] trap_tid,
    output logic                        rsp_valid,
    output logic [$clog2(NTHREADS)-1:0] rsp_tid,
    output logic [DW-1:0]               rsp_data
);

    localparam int TIDW = $clog2(NTHREADS);
    localparam int TAGW = AW - BLK_LOG2;

    typedef struct packed {
        logic            vld;
        logic [TIDW-1:0] tid;
        logic [DW-1:0]   data;
    } rsp_t;

    mem_op_e         op;
    logic [TAGW-1:0] req_tag;
    logic [NTHREADS-1:0] resv_vld;
    logic [TAGW-1:0] resv_tag [NTHREADS];
    logic            own_vld;
    logic [TAGW-1:0] own_tag;
    logic            sc_ok;
    logic            mem_we;
    logic [DW-1:0]   mem_rdata;
    rsp_t            rsp_d, rsp_q;

    assign op      = mem_op_e'(req_op);
    assign req_tag = req_addr[AW-1:BLK_LOG2];

    for (genvar t = 0; t < NTHREADS; t++) begin : g_slot
        resv_slot #(
            .TID (t),
            .TIDW(TIDW),
            .TAGW(TAGW)
        ) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .req_valid (req_valid),
            .req_op    (op),
            .req_tid   (req_tid),
            .req_tag   (req_tag),
            .mem_write (mem_we),
            .trap_valid(trap_valid),
            .trap_tid  (trap_tid),
            .slot_vld  (resv_vld[t]),
            .slot_tag  (resv_tag[t])
        );
    end

    always_comb begin
        own_vld = 1'b0;
        own_tag = '0;
        for (int t = 0; t < NTHREADS; t++) begin
            if (req_tid == TIDW'(t)) begin
                own_vld = resv_vld[t];
                own_tag = resv_tag[t];
            end
        end
    end

    assign sc_ok  = req_valid && (op == OP_SC) && own_vld && (own_tag == req_tag)
                    && !(trap_valid && trap_tid == req_tid);
    assign mem_we = req_valid && ((op == OP_STORE) || sc_ok);

    resv_mem #(
        .AW(AW),
        .DW(DW)
    ) u_mem (
        .clk  (clk),
        .rst_n(rst_n),
        .wr_en(mem_we),
        .addr (req_addr),
        .wdata(req_wdata),
        .rdata(mem_rdata)
    );

    always_comb begin
        rsp_d     = '0;
        rsp_d.vld = req_valid;
        rsp_d.tid = req_tid;
        unique case (op)
            OP_LOAD, OP_LL: rsp_d.data = mem_rdata;
            OP_SC:          rsp_d.data = DW'(sc_ok);
            default:        rsp_d.data = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rsp_valid = rsp_q.vld;
    assign rsp_tid   = rsp_q.tid;
    assign rsp_data  = rsp_q.data;

endmodule

// File: rtl/resv_monitor_chk.sv
module resv_monitor_chk
    import resv_pkg::*;
#(
    parameter int NTHREADS = 4,
    parameter int DW       = 32
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        req_valid,
    input logic [1:0]                  req_op,
    input logic [$clog2(NTHREADS)-1:0] req_tid,
    input logic                        trap_valid,
    input logic [$clog2(NTHREADS)-1:0] trap_tid,
    input logic                        rsp_valid,
    input logic [$clog2(NTHREADS)-1:0] rsp_tid,
    input logic [DW-1:0]               rsp_data,
    input logic [NTHREADS-1:0]         resv_vld
);

    // R2
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R2
    no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    // R2
    rsp_tid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_tid == $past(req_tid));

    // R3
    sc_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == OP_SC) |=> rsp_data[DW-1:1] == '0);

    // R5
    sc_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == OP_SC) |=> !resv_vld[$past(req_tid)]);

    // R7
    trap_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_valid |=> !resv_vld[$past(trap_tid)]);

    // R8
    ll_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == OP_LL && !(trap_valid && trap_tid == req_tid))
        |=> resv_vld[$past(req_tid)]);

endmodule

bind resv_monitor resv_monitor_chk #(
    .NTHREADS(NTHREADS),
    .DW      (DW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_op    (req_op),
    .req_tid   (req_tid),
    .trap_valid(trap_valid),
    .trap_tid  (trap_tid),
    .rsp_valid (rsp_valid),
    .rsp_tid   (rsp_tid),
    .rsp_data  (rsp_data),
    .resv_vld  (resv_vld)
);

// File: tb/tb_resv_monitor.sv
module tb_resv_monitor;

    localparam int NT = 4;
    localparam int AW = 8;
    localparam int DW = 32;
    localparam int TW = 2;

    localparam logic [1:0] LD = 2'd0;
    localparam logic [1:0] ST = 2'd1;
    localparam logic [1:0] LL = 2'd2;
    localparam logic [1:0] SC = 2'd3;

    typedef struct {
        logic [TW-1:0] tid;
        logic [DW-1:0] data;
        string         req;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [1:0]    req_op = '0;
    logic [TW-1:0] req_tid = '0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          trap_valid = 1'b0;
    logic [TW-1:0] trap_tid = '0;
    logic          rsp_valid;
    logic [TW-1:0] rsp_tid;
    logic [DW-1:0] rsp_data;

    exp_t exp_q[$];
    int   n_checks = 0;
    int   n_fails  = 0;
    int   cycles   = 0;
    bit   done     = 1'b0;

    always #10 clk = ~clk;

    resv_monitor #(
        .NTHREADS(NT),
        .AW      (AW),
        .DW      (DW),
        .BLK_LOG2(4)
    ) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_op    (req_op),
        .req_tid   (req_tid),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .trap_valid(trap_valid),
        .trap_tid  (trap_tid),
        .rsp_valid (rsp_valid),
        .rsp_tid   (rsp_tid),
        .rsp_data  (rsp_data)
    );

    task automatic issue(input logic [1:0] op, input int tid, input int addr,
                         input logic [DW-1:0] wd, input logic [DW-1:0] expd,
                         input string req, input bit trap = 1'b0, input int ttid = 0);
        exp_t e;
        @(negedge clk);
        req_valid  = 1'b1;
        req_op     = op;
        req_tid    = TW'(tid);
        req_addr   = AW'(addr);
        req_wdata  = wd;
        trap_valid = trap;
        trap_tid   = TW'(ttid);
        e.tid  = TW'(tid);
        e.data = expd;
        e.req  = req;
        exp_q.push_back(e);
        @(negedge clk);
        req_valid  = 1'b0;
        trap_valid = 1'b0;
    endtask

    task automatic trap_only(input int ttid);
        @(negedge clk);
        trap_valid = 1'b1;
        trap_tid   = TW'(ttid);
        @(negedge clk);
        trap_valid = 1'b0;
    endtask

    // monitor: responses are valid after the edge that took the request
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            n_checks++;
            if (exp_q.size() == 0) begin
                n_fails++;
                $display("FAIL R2 unexpected response tid=%0d data=%h expected none",
                         rsp_tid, rsp_data);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                if (rsp_tid !== e.tid || rsp_data !== e.data) begin
                    n_fails++;
                    $display("FAIL %s tid=%0d data=%h expected tid=%0d data=%h",
                             e.req, rsp_tid, rsp_data, e.tid, e.data);
                end
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            done = 1'b1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog expired after %0d cycles, expected completion", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: no response while in reset
        n_checks++;
        if (rsp_valid !== 1'b0) begin
            n_fails++;
            $display("FAIL R1 rsp_valid=%b expected 0", rsp_valid);
        end
        rst_n = 1'b1;

        // R1: no reservation after reset, nothing written
        issue(SC, 0, 'h05, 32'hAA, 32'd0, "R1");
        issue(LD, 0, 'h05, 32'h0, 32'd0, "R1");

        // R2 / R3 / R4 / R5
        issue(ST, 1, 'h05, 32'h1234, 32'd0, "R4");
        issue(LL, 0, 'h05, 32'h0, 32'h1234, "R2");
        issue(SC, 0, 'h06, 32'h55, 32'd1, "R3");
        issue(LD, 2, 'h06, 32'h0, 32'h55, "R3");
        issue(SC, 0, 'h06, 32'h66, 32'd0, "R5");
        issue(LD, 2, 'h06, 32'h0, 32'h55, "R4");

        // R6: other-block store keeps, same-block store clears
        issue(LL, 1, 'h20, 32'h0, 32'd0, "R2");
        issue(ST, 2, 'h40, 32'h7, 32'd0, "R6");
        issue(SC, 1, 'h21, 32'h11, 32'd1, "R6");
        issue(LL, 1, 'h20, 32'h0, 32'd0, "R2");
        issue(ST, 2, 'h2F, 32'h9, 32'd0, "R6");
        issue(SC, 1, 'h20, 32'h22, 32'd0, "R6");
        issue(LD, 1, 'h20, 32'h0, 32'd0, "R6");

        // R7: trap on other thread keeps, trap on owner clears
        issue(LL, 2, 'h30, 32'h0, 32'd0, "R2");
        trap_only(3);
        issue(SC, 2, 'h30, 32'h5, 32'd1, "R7");
        issue(LL, 2, 'h30, 32'h0, 32'h5, "R2");
        trap_only(2);
        issue(SC, 2, 'h30, 32'h6, 32'd0, "R7");
        issue(LD, 2, 'h30, 32'h0, 32'h5, "R7");

        // R8: newer LL replaces older reservation
        issue(LL, 3, 'h50, 32'h0, 32'd0, "R8");
        issue(LL, 3, 'h60, 32'h0, 32'd0, "R8");
        issue(SC, 3, 'h50, 32'h3, 32'd0, "R8");
        issue(LL, 3, 'h50, 32'h0, 32'd0, "R8");
        issue(LL, 3, 'h60, 32'h0, 32'd0, "R8");
        issue(SC, 3, 'h60, 32'h8, 32'd1, "R8");

        // R9: winning SC clears peers; losing SC clears nobody else
        issue(LL, 0, 'h70, 32'h0, 32'd0, "R9");
        issue(LL, 1, 'h71, 32'h0, 32'd0, "R9");
        issue(SC, 1, 'h72, 32'hC, 32'd1, "R9");
        issue(SC, 0, 'h70, 32'hD, 32'd0, "R9");
        issue(LD, 0, 'h70, 32'h0, 32'd0, "R9");
        issue(LL, 0, 'h80, 32'h0, 32'd0, "R9");
        issue(SC, 1, 'h80, 32'h1, 32'd0, "R9");
        issue(SC, 0, 'h80, 32'h2, 32'd1, "R9");

        // R10: own store clears, own load keeps
        issue(LL, 2, 'h90, 32'h0, 32'd0, "R10");
        issue(ST, 2, 'h91, 32'h4, 32'd0, "R10");
        issue(SC, 2, 'h90, 32'h5, 32'd0, "R10");
        issue(LL, 2, 'h90, 32'h0, 32'd0, "R10");
        issue(LD, 2, 'h91, 32'h0, 32'h4, "R10");
        issue(SC, 2, 'h90, 32'h5, 32'd1, "R10");

        // R11: trap in the same cycle as the owner's SC
        issue(LL, 3, 'hA0, 32'h0, 32'd0, "R11");
        issue(SC, 3, 'hA0, 32'hE, 32'd0, "R11", 1'b1, 3);
        issue(LD, 3, 'hA0, 32'h0, 32'd0, "R11");

        repeat (4) @(negedge clk);
        n_checks++;
        if (exp_q.size() != 0) begin
            n_fails++;
            $display("FAIL R2 %0d responses missing, expected 0", exp_q.size());
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule